// File: doc/BRIEF.md
# Micro-op integer ALU with partial-width merge

This block executes one integer register micro-op per accepted cycle on a 64-bit datapath. Each micro-op takes its first operand from a source register. Its second operand is either a second source register or an 8-bit immediate, which is zero-extended before use. The operand size selects 1, 2, 4 or 8 bytes. Only that many low bytes of the destination change. All higher bits keep the destination's previous value, so the register file can write the returned word back as it is.

Besides the add, subtract, carry/borrow and bitwise operations, the block handles a compare that updates only the flags and a move that overlays the second operand onto the first source. It also writes the instruction pointer, reads the instruction pointer into a register, and sign-extends from a bit count carried in the immediate. Results, flags and the instruction-pointer value are registered and appear one clock after the micro-op is presented. Each one comes with its own write enable.

Top module: `uop_alu`

## Requirements
- R1: When `use_imm_i` is 1, the second operand is `imm_i` zero-extended to 64 bits; when it is 0, the second operand is `src2_i`.
- R2: `op_i` codes are ADD=0, OR=1, ADC=2, SBB=3, AND=4, SUB=5, XOR=6. For these, the result is computed from `src1_i` and the second operand. The low operand-size bytes of `dest_data_o` take the result, and the higher bits equal `dest_old_i`. `size_i` codes 0/1/2/3 mean 1/2/4/8 bytes.
- R3: MOV (code 8) writes `src1_i` with its low operand-size bytes replaced by the second operand.
- R4: CMP (code 7) computes `dest_old_i` minus the second operand. It never asserts `dest_we_o` and always asserts `flags_we_o`, whatever the value of `set_status_i`.
- R5: For ADD, ADC, SUB, SBB and CMP, the flags are computed at the operand size. CF is the carry or borrow out of the top bit of that size. SF is the result's top bit at that size. OF is the signed overflow at that size. ADC adds `carry_i` and SBB subtracts it.
- R6: For OR, AND and XOR with set-status, CF and OF are 0 and SF is the result's top bit at the operand size.
- R7: Apart from CMP, flags are written only when `set_status_i` is 1 and the code is 0..6. MOV, WRIP, RDIP and SEXT never write flags.
- R8: WRIP (code 9) asserts `ip_we_o` with `ip_data_o` = `src1_i` + second operand (full 64 bits). It writes neither the register destination nor the flags.
- R9: RDIP (code 10) writes `ip_i` to the destination in full and uses no source operand.
- R10: SEXT (code 11) takes `imm_i` as a count N. If N is 1..63 and bit N-1 of `src1_i` is 1, then bits N and above are set to 1. Otherwise the value passes through unchanged. The value is then merged into `dest_old_i` at the operand size.
- R11: Outputs follow the inputs with one clock of latency. A cycle with `valid_i` low produces no write enable in the next cycle. After reset, all outputs are 0.
- R12: Codes 12..15 assert no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Micro-op present this cycle |
| op_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Second operand from immediate |
| src1_i | input | 64 | First source value |
| src2_i | input | 64 | Second source value |
| dest_old_i | input | 64 | Current destination value |
| imm_i | input | 8 | Immediate |
| size_i | input | 2 | Operand size code |
| set_status_i | input | 1 | Enable flag update |
| ip_i | input | 64 | Current instruction pointer |
| carry_i | input | 1 | Carry flag in |
| dest_we_o | output | 1 | Destination write enable |
| dest_data_o | output | 64 | Merged destination value |
| flags_we_o | output | 1 | Flag write enable |
| flag_cf_o | output | 1 | Carry flag |
| flag_of_o | output | 1 | Overflow flag |
| flag_sf_o | output | 1 | Sign flag |
| ip_we_o | output | 1 | Instruction-pointer write enable |
| ip_data_o | output | 64 | New instruction pointer |

## Verification
The properties relate each output cycle to the inputs sampled on the clock before it. They therefore assume that every input is driven to a known value whenever `valid_i` is high, and that `valid_i` is held low during reset. The stimulus changes inputs only on the falling clock edge and keeps `valid_i` low until reset has been released. It mixes directed corner values with pseudo-random operands. These cover every size, every code including the undefined ones, and sign-extend counts of 0, 63, 64 and above.

// File: rtl/uop_alu_pkg.sv
package uop_alu_pkg;
  typedef enum logic [3:0] {
    UOP_ADD  = 4'd0,
    UOP_OR   = 4'd1,
    UOP_ADC  = 4'd2,
    UOP_SBB  = 4'd3,
    UOP_AND  = 4'd4,
    UOP_SUB  = 4'd5,
    UOP_XOR  = 4'd6,
    UOP_CMP  = 4'd7,
    UOP_MOV  = 4'd8,
    UOP_WRIP = 4'd9,
    UOP_RDIP = 4'd10,
    UOP_SEXT = 4'd11
  } uop_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
  } flags_t;
endpackage

// File: rtl/uop_operand_sel.sv
module uop_operand_sel #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  parameter int SIZE_W = 2,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] op2_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [IDX_W-1:0]  msb_o
);
  logic [IDX_W:0] bytes_n;

  assign op2_o   = use_imm_i ? {{(DATA_W-IMM_W){1'b0}}, imm_i} : src2_i;
  assign bytes_n = (IDX_W+1)'(1) << size_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mask_o[l*8 +: 8] = ((IDX_W+1)'(l) < bytes_n) ? 8'hFF : 8'h00;
  end

  always_comb begin
    logic [IDX_W+3:0] bits_n;
    bits_n = (IDX_W+4)'(bytes_n) << 3;
    msb_o  = IDX_W'(bits_n - 1'b1);
  end
endmodule

// File: rtl/uop_sext_unit.sv
module uop_sext_unit #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [IMM_W-1:0]  count_i,
  output logic [DATA_W-1:0] res_o
);
  logic             in_range;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] sign_pos;
  logic [DATA_W-1:0] hi_mask;

  assign in_range = (count_i != '0) && (count_i < IMM_W'(DATA_W));
  assign cnt      = IDX_W'(count_i);
  assign sign_pos = cnt - 1'b1;
  assign hi_mask  = {DATA_W{1'b1}} << cnt;
  assign res_o    = (in_range && val_i[sign_pos]) ? (val_i | hi_mask) : val_i;
endmodule

// File: rtl/uop_arith_core.sv
module uop_arith_core
  import uop_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  uop_e              op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [IDX_W-1:0]  msb_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  logic [DATA_W-1:0] am, bm;
  logic [DATA_W:0]   sum, diff;
  logic              cin_add, cin_sub;
  logic [IDX_W:0]    cpos;

  assign am      = a_i & mask_i;
  assign bm      = b_i & mask_i;
  assign cin_add = (op_i == UOP_ADC) & carry_i;
  assign cin_sub = (op_i == UOP_SBB) & carry_i;
  assign sum     = {1'b0, am} + {1'b0, bm} + (DATA_W+1)'(cin_add);
  assign diff    = {1'b0, am} - {1'b0, bm} - (DATA_W+1)'(cin_sub);
  assign cpos    = {1'b0, msb_i} + 1'b1;

  always_comb begin
    res_o   = '0;
    flags_o = '0;
    unique case (op_i)
      UOP_ADD, UOP_ADC: begin
        res_o      = sum[DATA_W-1:0];
        flags_o.cf = sum[cpos];
        flags_o.of = (am[msb_i] == bm[msb_i]) && (res_o[msb_i] != am[msb_i]);
      end
      UOP_SUB, UOP_SBB, UOP_CMP: begin
        res_o      = diff[DATA_W-1:0];
        flags_o.cf = diff[cpos];
        flags_o.of = (am[msb_i] != bm[msb_i]) && (res_o[msb_i] != am[msb_i]);
      end
      UOP_OR:  res_o = a_i | b_i;
      UOP_AND: res_o = a_i & b_i;
      UOP_XOR: res_o = a_i ^ b_i;
      default: res_o = b_i;
    endcase
    flags_o.sf = res_o[msb_i];
  end
endmodule

// File: rtl/uop_alu.sv
module uop_alu
  import uop_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  parameter int SIZE_W = 2,
  parameter int OP_W   = 4,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [DATA_W-1:0] dest_old_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              set_status_i,
  input  logic [DATA_W-1:0] ip_i,
  input  logic              carry_i,
  output logic              dest_we_o,
  output logic [DATA_W-1:0] dest_data_o,
  output logic              flags_we_o,
  output logic              flag_cf_o,
  output logic              flag_of_o,
  output logic              flag_sf_o,
  output logic              ip_we_o,
  output logic [DATA_W-1:0] ip_data_o
);
  uop_e              op;
  logic [DATA_W-1:0] op2, mask, lhs, alu_res, sext_res, new_val, base, merged;
  logic [IDX_W-1:0]  msb;
  flags_t            alu_flags;
  logic              is_alu, d_we, f_we, i_we;

  assign op = uop_e'(op_i);

  uop_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W)) u_opsel (
    .use_imm_i(use_imm_i), .src2_i(src2_i), .imm_i(imm_i), .size_i(size_i),
    .op2_o(op2), .mask_o(mask), .msb_o(msb)
  );

  // compare takes the destination as its left operand
  assign lhs = (op == UOP_CMP) ? dest_old_i : src1_i;

  uop_arith_core #(.DATA_W(DATA_W)) u_core (
    .op_i(op), .a_i(lhs), .b_i(op2), .carry_i(carry_i),
    .mask_i(mask), .msb_i(msb), .res_o(alu_res), .flags_o(alu_flags)
  );

  uop_sext_unit #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sext (
    .val_i(src1_i), .count_i(imm_i), .res_o(sext_res)
  );

  assign is_alu  = (op_i <= OP_W'(UOP_XOR));
  assign new_val = (op == UOP_SEXT) ? sext_res : alu_res;
  assign base    = (op == UOP_MOV) ? src1_i : dest_old_i;
  assign merged  = (op == UOP_RDIP) ? ip_i : ((base & ~mask) | (new_val & mask));

  assign d_we = valid_i & (is_alu | (op_i == OP_W'(UOP_MOV)) |
                           (op_i == OP_W'(UOP_RDIP)) | (op_i == OP_W'(UOP_SEXT)));
  assign f_we = valid_i & ((op_i == OP_W'(UOP_CMP)) | (is_alu & set_status_i));
  assign i_we = valid_i & (op_i == OP_W'(UOP_WRIP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_we_o   <= 1'b0;
      dest_data_o <= '0;
      flags_we_o  <= 1'b0;
      flag_cf_o   <= 1'b0;
      flag_of_o   <= 1'b0;
      flag_sf_o   <= 1'b0;
      ip_we_o     <= 1'b0;
      ip_data_o   <= '0;
    end else begin
      dest_we_o  <= d_we;
      flags_we_o <= f_we;
      ip_we_o    <= i_we;
      if (d_we) dest_data_o <= merged;
      if (f_we) begin
        flag_cf_o <= alu_flags.cf;
        flag_of_o <= alu_flags.of;
        flag_sf_o <= alu_flags.sf;
      end
      if (i_we) ip_data_o <= src1_i + op2;
    end
  end
endmodule

// File: rtl/uop_alu_chk.sv
module uop_alu_chk
  import uop_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  parameter int SIZE_W = 2,
  parameter int OP_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] src1_i,
  input logic [DATA_W-1:0] dest_old_i,
  input logic [SIZE_W-1:0] size_i,
  input logic              set_status_i,
  input logic [DATA_W-1:0] ip_i,
  input logic              dest_we_o,
  input logic [DATA_W-1:0] dest_data_o,
  input logic              flags_we_o,
  input logic              flag_cf_o,
  input logic              flag_of_o,
  input logic              ip_we_o
);
  AST_CMP_FLAGS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_W'(UOP_CMP) |=> !dest_we_o && flags_we_o); // R4

  AST_MERGE_KEEPS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == '0 && (op_i <= OP_W'(UOP_XOR) || op_i == OP_W'(UOP_SEXT))
    |=> dest_data_o[DATA_W-1:8] == $past(dest_old_i[DATA_W-1:8])); // R2

  AST_MOV_KEEPS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == '0 && op_i == OP_W'(UOP_MOV)
    |=> dest_data_o[DATA_W-1:8] == $past(src1_i[DATA_W-1:8])); // R3

  AST_LOGIC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && set_status_i && (op_i == OP_W'(UOP_OR) || op_i == OP_W'(UOP_AND) ||
    op_i == OP_W'(UOP_XOR)) |=> flags_we_o && !flag_cf_o && !flag_of_o); // R6

  AST_NO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !set_status_i && op_i != OP_W'(UOP_CMP) |=> !flags_we_o); // R7

  AST_WRIP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_W'(UOP_WRIP) |=> ip_we_o && !dest_we_o && !flags_we_o); // R8

  AST_RDIP_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_W'(UOP_RDIP) |=> dest_we_o && dest_data_o == $past(ip_i)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !dest_we_o && !flags_we_o && !ip_we_o); // R11

  AST_UNDEF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i > OP_W'(UOP_SEXT) |=> !dest_we_o && !flags_we_o && !ip_we_o); // R12

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dest_we_o && ip_we_o)); // R8
endmodule

bind uop_alu uop_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W), .OP_W(OP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .src1_i(src1_i),
  .dest_old_i(dest_old_i), .size_i(size_i), .set_status_i(set_status_i), .ip_i(ip_i),
  .dest_we_o(dest_we_o), .dest_data_o(dest_data_o), .flags_we_o(flags_we_o),
  .flag_cf_o(flag_cf_o), .flag_of_o(flag_of_o), .ip_we_o(ip_we_o)
);

// File: tb/tb_uop_alu.sv
module tb_uop_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        use_imm_i = 1'b0;
  logic [63:0] src1_i = '0, src2_i = '0, dest_old_i = '0, ip_i = '0;
  logic [7:0]  imm_i = '0;
  logic [1:0]  size_i = '0;
  logic        set_status_i = 1'b0;
  logic        carry_i = 1'b0;
  logic        dest_we_o, flags_we_o, flag_cf_o, flag_of_o, flag_sf_o, ip_we_o;
  logic [63:0] dest_data_o, ip_data_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uop_alu dut (.*);

  typedef struct {
    string       req;
    logic        dwe;
    logic [63:0] dval;
    logic        fwe;
    logic        cf, of, sf;
    logic        iwe;
    logic [63:0] ival;
  } exp_t;

  exp_t sb_q[$];

  function automatic exp_t model(string req, logic v, logic [3:0] op, logic ui,
      logic [63:0] s1, logic [63:0] s2, logic [63:0] old, logic [7:0] imm,
      logic [1:0] sz, logic ss, logic [63:0] ip, logic c);
    exp_t e;
    int nb;
    logic [63:0] m, b, a, r;
    logic [65:0] wide;
    e = '{req: req, dwe: 0, dval: 0, fwe: 0, cf: 0, of: 0, sf: 0, iwe: 0, ival: 0};
    if (!v || op > 4'd11) return e;
    nb = 8 * (1 << sz);
    m  = (nb == 64) ? {64{1'b1}} : ((64'd1 << nb) - 64'd1);
    b  = ui ? {56'd0, imm} : s2;
    a  = (op == 4'd7) ? old : s1;
    r  = '0;
    case (op)
      4'd0, 4'd2: begin
        wide = {2'b0, a & m} + {2'b0, b & m} + ((op == 4'd2 && c) ? 66'd1 : 66'd0);
        r    = wide[63:0];
        e.cf = (wide >> nb) != 0;
        e.of = (a[nb-1] == b[nb-1]) && (r[nb-1] != a[nb-1]);
      end
      4'd3, 4'd5, 4'd7: begin
        wide = {2'b0, b & m} + ((op == 4'd3 && c) ? 66'd1 : 66'd0);
        e.cf = {2'b0, a & m} < wide;
        r    = (a & m) - wide[63:0];
        e.of = (a[nb-1] != b[nb-1]) && (r[nb-1] != a[nb-1]);
      end
      4'd1: r = a | b;
      4'd4: r = a & b;
      4'd6: r = a ^ b;
      4'd8: r = b;
      4'd11: begin
        r = s1;
        if (imm >= 8'd1 && imm <= 8'd63 && s1[imm-1])
          for (int i = 0; i < 64; i++) if (i >= imm) r[i] = 1'b1;
      end
      default: r = '0;
    endcase
    e.sf = r[nb-1];
    if (op <= 4'd6 || op == 4'd8 || op == 4'd11) begin
      e.dwe  = 1;
      e.dval = (((op == 4'd8) ? s1 : old) & ~m) | (r & m);
    end
    if (op == 4'd10) begin e.dwe = 1; e.dval = ip; end
    if (op == 4'd7 || (op <= 4'd6 && ss)) e.fwe = 1;
    if (!e.fwe) begin e.cf = 0; e.of = 0; e.sf = 0; end
    if (op == 4'd9) begin e.iwe = 1; e.ival = s1 + b; end
    return e;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(string req, logic v, logic [3:0] op, logic ui, logic [63:0] s1,
      logic [63:0] s2, logic [63:0] old, logic [7:0] imm, logic [1:0] sz, logic ss,
      logic [63:0] ip, logic c);
    @(negedge clk_i);
    valid_i = v; op_i = op; use_imm_i = ui; src1_i = s1; src2_i = s2;
    dest_old_i = old; imm_i = imm; size_i = sz; set_status_i = ss; ip_i = ip; carry_i = c;
    sb_q.push_back(model(req, v, op, ui, s1, s2, old, imm, sz, ss, ip, c));
  endtask

  task automatic idle();
    drive("R11", 1'b0, 4'd0, 1'b0, '0, '0, '0, '0, 2'd0, 1'b0, '0, 1'b0);
  endtask

  // monitor: each expected item is due one clock after it was driven
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, "dest_we", 64'(dest_we_o), 64'(e.dwe));
        if (e.dwe) chk(e.req, "dest_data", dest_data_o, e.dval);
        chk(e.req, "flags_we", 64'(flags_we_o), 64'(e.fwe));
        if (e.fwe) chk(e.req, "flags cf/of/sf", 64'({flag_cf_o, flag_of_o, flag_sf_o}),
                       64'({e.cf, e.of, e.sf}));
        chk(e.req, "ip_we", 64'(ip_we_o), 64'(e.iwe));
        if (e.iwe) chk(e.req, "ip_data", ip_data_o, e.ival);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  localparam logic [63:0] OLD = 64'hAAAA_BBBB_CCCC_DDDD;

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R11 reset state
    chk("R11", "reset outputs", 64'({dest_we_o, flags_we_o, ip_we_o, flag_cf_o, flag_of_o, flag_sf_o}), 64'd0);
    chk("R11", "reset dest_data", dest_data_o, 64'd0);
    chk("R11", "reset ip_data", ip_data_o, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    // R1 immediate vs register, R2 merge, R5 byte carry
    drive("R1", 1, 4'd0, 1, 64'h1122_3344_5566_77F0, 64'hFFFF, OLD, 8'h20, 2'd0, 1, '0, 0);
    drive("R1", 1, 4'd0, 0, 64'h1122_3344_5566_77F0, 64'h0000_0000_0000_0105, OLD, 8'h20, 2'd1, 1, '0, 0);
    drive("R2", 1, 4'd1, 1, 64'h0F0F_0F0F_0F0F_0F0F, '0, OLD, 8'hF0, 2'd2, 0, '0, 0);
    drive("R2", 1, 4'd4, 0, 64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0, OLD, 8'h0, 2'd3, 0, '0, 0);
    drive("R2", 1, 4'd6, 0, 64'h8000_0000_0000_0080, 64'h1, OLD, 8'h0, 2'd0, 0, '0, 0);
    // R5 signed overflow at each size, carry/borrow in
    drive("R5", 1, 4'd0, 1, 64'h7F, '0, OLD, 8'h01, 2'd0, 1, '0, 0);
    drive("R5", 1, 4'd5, 0, 64'h0000_0000_8000_0000, 64'h1, OLD, 8'h0, 2'd2, 1, '0, 0);
    drive("R5", 1, 4'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, OLD, 8'h0, 2'd3, 1, '0, 1);
    drive("R5", 1, 4'd3, 0, 64'h0, 64'h0, OLD, 8'h0, 2'd1, 1, '0, 1);
    drive("R5", 1, 4'd3, 0, 64'h5, 64'h2, OLD, 8'h0, 2'd3, 1, '0, 0);
    // R6 logic flags
    drive("R6", 1, 4'd1, 0, 64'h80, 64'h0, OLD, 8'h0, 2'd0, 1, '0, 1);
    drive("R6", 1, 4'd6, 0, 64'h8000_0000_0000_0000, 64'h0, OLD, 8'h0, 2'd3, 1, '0, 1);
    // R4 compare with and without set-status
    drive("R4", 1, 4'd7, 1, 64'h99, '0, 64'h0000_0000_0000_0010, 8'h20, 2'd0, 0, '0, 0);
    drive("R4", 1, 4'd7, 0, 64'h99, 64'h10, 64'h10, 8'h0, 2'd3, 1, '0, 0);
    // R3 move
    drive("R3", 1, 4'd8, 0, 64'h1111_2222_3333_4444, 64'hDEAD_BEEF_CAFE_F00D, OLD, 8'h0, 2'd1, 1, '0, 0);
    drive("R3", 1, 4'd8, 1, 64'h1111_2222_3333_4444, '0, OLD, 8'h5A, 2'd2, 0, '0, 0);
    // R7 no status writes no flags
    drive("R7", 1, 4'd0, 0, 64'hFF, 64'h1, OLD, 8'h0, 2'd0, 0, '0, 0);
    // R8 write-IP, R9 read-IP
    drive("R8", 1, 4'd9, 1, 64'h0000_7FFF_FFFF_FFF0, '0, OLD, 8'h40, 2'd0, 1, 64'h1234, 0);
    drive("R9", 1, 4'd10, 0, 64'h5, 64'h6, OLD, 8'h0, 2'd0, 1, 64'hFEED_0000_BEEF_1234, 0);
    // R10 sign-extend corners
    drive("R10", 1, 4'd11, 1, 64'h0000_0000_0000_0080, '0, OLD, 8'd8, 2'd3, 0, '0, 0);
    drive("R10", 1, 4'd11, 1, 64'h0000_0000_0000_0080, '0, OLD, 8'd8, 2'd1, 0, '0, 0);
    drive("R10", 1, 4'd11, 1, 64'h0000_0000_0000_0040, '0, OLD, 8'd8, 2'd3, 0, '0, 0);
    drive("R10", 1, 4'd11, 1, 64'h8000_0000_0000_0001, '0, OLD, 8'd0, 2'd3, 0, '0, 0);
    drive("R10", 1, 4'd11, 1, 64'h4000_0000_0000_0000, '0, OLD, 8'd63, 2'd3, 0, '0, 0);
    drive("R10", 1, 4'd11, 1, 64'hFFFF_FFFF_0000_0001, '0, OLD, 8'd64, 2'd3, 0, '0, 0);
    drive("R10", 1, 4'd11, 1, 64'h1, '0, OLD, 8'd200, 2'd3, 0, '0, 0);
    // R12 undefined codes
    for (int k = 12; k < 16; k++)
      drive("R12", 1, 4'(k), 0, 64'h1, 64'h2, OLD, 8'h3, 2'd3, 1, 64'h4, 1);
    idle();
    // mixed pseudo-random traffic across all codes and sizes
    for (int k = 0; k < 400; k++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      drive((op == 4'd7) ? "R4" : (op == 4'd9) ? "R8" : (op == 4'd11) ? "R10" : "R2",
            1'($urandom_range(0, 4) != 0), op, 1'($urandom), {$urandom, $urandom},
            {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom_range(0, 70)),
            2'($urandom), 1'($urandom), {$urandom, $urandom}, 1'($urandom));
    end
    idle();
    idle();
    wait (sb_q.size() == 0);
    @(posedge clk_i);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule